// File: doc/BRIEF.md
# Flash sector address and buffer decoder

This block sits in a NAND-style flash controller and turns the values that software leaves in its address and buffer registers into the numbers the data-movement engine needs. Eight 16-bit address registers hold block and page numbers, split across separate registers. One further register packs the choice of internal buffer and the number of sectors to move. From these the block derives a linear sector index for the source of an operation, a second index for the destination of a copy-back, the first sector of the erase block, the buffer selection and the sector count.

All accesses use a simple 16-bit register bus with a 4-bit index, a write strobe and a read strobe. Derived outputs are registered, so they follow a write after a fixed delay and stay stable between writes. The page size (2 KB or 1 KB) and the device identifier that sets the high-block density mask are synthesis parameters.

Top module: `flash_sector_decoder`

## Requirements
- R1: After reset every address register reads 0, the buffer register reads 0x0002 (buffer address 0, count 4 in 2 KB mode), all sector outputs are 0, `bufIsData`, `bufDataSel` and `bufSecOfs` are 0 and `secCount` is 4.
- R2: A write to index 0..7 stores all 16 bits, and a read of that index returns the stored value unchanged.
- R3: The source sector is `(P[1:0]) + ((P[7:2] + (F << 6)) << (PAGE_SHIFT-9))`, where P is the page register at index 7 and F is the block field of the block register at index 0. Page bits 15:8 are ignored.
- R4: The block field F is bits 11:0 of the block register, ORed with a density mask only when bit 15 is set; bits 14:12 are ignored. The mask is `1 << (6 + DEV_ID[6:4])` when `DEV_ID[3]` is 1, else 0 (default DEV_ID 0x48 gives 0x400).
- R5: The destination sector uses the same formula with the block register at index 2 and the page register at index 3, independent of indices 0 and 7.
- R6: `eraseBase` is `F << (PAGE_SHIFT-3)` for the source block, and `eraseCount` is `1 << (PAGE_SHIFT-3)` (256 for 2 KB pages).
- R7: A write to index 8 stores bits 11:8 as the buffer address: bit 11 drives `bufIsData` (1 = data buffer, 0 = boot buffer), bit 10 drives `bufDataSel` (data buffer 1 or 0), bits 9:8 drive `bufSecOfs`. Bits 15:12 are ignored.
- R8: In 2 KB mode `secCount` is bits 1:0 of the index-8 write with 0 meaning 4; in 1 KB mode it is bit 0 with 0 meaning 2.
- R9: A read of index 8 returns `(bufaddr << 8) | ((secCount - 1) & (1 << (PAGE_SHIFT-10)))`.
- R10: Reads of indices 9..15 return 0, and writes to them change no register and no output.
- R11: Derived outputs change on the second rising clock edge after the one that samples the write; after the first edge they still show the old value.
- R12: `rdData` is loaded on the rising edge that samples `rdEn` and holds its value while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regIdx | input | 4 | Register index for both reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Read data, one edge after the strobe |
| srcSector | output | 23 | Linear source sector index |
| dstSector | output | 23 | Linear copy-back destination sector index |
| eraseBase | output | 22 | First sector of the source erase block |
| eraseCount | output | 16 | Sectors per erase block |
| bufIsData | output | 1 | 1 = data buffer, 0 = boot buffer |
| bufDataSel | output | 1 | Data buffer number |
| bufSecOfs | output | 2 | Sector offset inside the buffer |
| secCount | output | 3 | Sectors to transfer |

## Verification
The sector formula is driven with block and page pairs that isolate each term: zero, a lone block bit, lone page and sector bits, a wide mixed pattern, and block values with bit 15 set or only bits 14:12 set, which separate a correct density mask from one that is missing, always applied or taken from the wrong bits. Page values with junk in the upper byte show whether bits 15:8 leak in. Buffer writes cover each count field including zero, and upper-nibble junk, so the read-back mask and the default count are told apart from a plain count echo. Destination registers are loaded with values unlike the source ones to expose a crossed register index.

// File: rtl/sec_dec_pkg.sv
package sec_dec_pkg;

  localparam int IDX_W         = 4;
  localparam int NUM_ADDR_REGS = 8;
  localparam int AREG_IDX_W    = $clog2(NUM_ADDR_REGS);

  // Register indices whose position the decode depends on
  localparam int SRC_BLK_IDX  = 0;
  localparam int SRC_PAGE_IDX = 7;
  localparam int DST_BLK_IDX  = 2;
  localparam int DST_PAGE_IDX = 3;
  localparam logic [IDX_W-1:0] BUF_REG_IDX = IDX_W'(8);

  // Strobes from control to datapath
  typedef struct packed {
    logic                  addrWr;
    logic                  bufWr;
    logic                  rdAddr;
    logic                  rdBuf;
    logic                  rdNone;
    logic [AREG_IDX_W-1:0] areg;
  } regStrobe_t;

endpackage

// File: rtl/sec_dec_ctrl.sv
module sec_dec_ctrl
  import sec_dec_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] regIdx,
  output regStrobe_t       strb
);

  logic inAddrRange;
  logic isBufReg;

  always_comb begin
    inAddrRange = (regIdx < IDX_W'(NUM_ADDR_REGS));
    isBufReg    = (regIdx == BUF_REG_IDX);
    strb.addrWr = wrEn && inAddrRange;
    strb.bufWr  = wrEn && isBufReg;
    strb.rdAddr = rdEn && inAddrRange;
    strb.rdBuf  = rdEn && isBufReg;
    strb.rdNone = rdEn && !inAddrRange && !isBufReg;
    strb.areg   = regIdx[AREG_IDX_W-1:0];
  end

endmodule

// File: rtl/sec_dec_path.sv
module sec_dec_path
  import sec_dec_pkg::*;
#(
  parameter int         PAGE_SHIFT = 11,
  parameter logic [7:0] DEV_ID     = 8'h48,
  parameter int         BLK_W      = 14,
  parameter int         SEC_W      = BLK_W + 6 + (PAGE_SHIFT - 9) + 1,
  parameter int         ERS_W      = BLK_W + 6 + (PAGE_SHIFT - 9),
  parameter int         CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  output logic [SEC_W-1:0] srcSector,
  output logic [SEC_W-1:0] dstSector,
  output logic [ERS_W-1:0] eraseBase,
  output logic [15:0]      eraseCount,
  output logic             bufIsData,
  output logic             bufDataSel,
  output logic [1:0]       bufSecOfs,
  output logic [CNT_W-1:0] secCount
);

  localparam int SUB_SHIFT = PAGE_SHIFT - 9;
  localparam int CNT_BITS  = SUB_SHIFT;
  localparam int CNT_MAX   = 1 << CNT_BITS;
  localparam int RB_MASK   = 1 << (CNT_BITS - 1);
  localparam int ERS_SHIFT = 6 + SUB_SHIFT;
  localparam int DENS_POS  = 6 + int'(DEV_ID[6:4]);
  localparam logic [BLK_W-1:0] DENS_MASK =
    DEV_ID[3] ? ({{(BLK_W-1){1'b0}}, 1'b1} << DENS_POS) : '0;

  logic [15:0]         addrRegs [NUM_ADDR_REGS];
  logic [3:0]          bufAddr;
  logic [1:0]          cntField;
  logic [CNT_W-1:0]    cntVal;
  logic [15:0]         bufRead;
  logic [BLK_W-1:0]    srcBlk;
  logic [SEC_W-1:0]    srcSecNxt;
  logic [SEC_W-1:0]    dstSecNxt;
  logic [ERS_W-1:0]    ersNxt;

  function automatic logic [BLK_W-1:0] blkField(input logic [15:0] r);
    blkField = {{(BLK_W-12){1'b0}}, r[11:0]} | (r[15] ? DENS_MASK : '0);
  endfunction

  function automatic logic [SEC_W-1:0] secOf(input logic [15:0] b,
                                             input logic [15:0] p);
    logic [SEC_W-1:0] t;
    t = SEC_W'({blkField(b), 6'b000000}) + SEC_W'(p[7:2]);
    secOf = (t << SUB_SHIFT) + SEC_W'(p[1:0]);
  endfunction

  // Address register file, one register per generated slice
  for (genvar g = 0; g < NUM_ADDR_REGS; g++) begin : gAreg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrRegs[g] <= '0;
      end else if (strb.addrWr && strb.areg == AREG_IDX_W'(g)) begin
        addrRegs[g] <= wrData;
      end
    end
  end

  // Buffer register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufAddr  <= '0;
      cntField <= '0;
    end else if (strb.bufWr) begin
      bufAddr  <= wrData[11:8];
      cntField <= '0;
      cntField[CNT_BITS-1:0] <= wrData[CNT_BITS-1:0];
    end
  end

  always_comb begin
    cntVal    = (cntField == '0) ? CNT_W'(CNT_MAX) : CNT_W'(cntField);
    bufRead   = {4'b0000, bufAddr, 8'h00}
              | 16'((cntVal - CNT_W'(1)) & CNT_W'(RB_MASK));
    srcBlk    = blkField(addrRegs[SRC_BLK_IDX]);
    srcSecNxt = secOf(addrRegs[SRC_BLK_IDX], addrRegs[SRC_PAGE_IDX]);
    dstSecNxt = secOf(addrRegs[DST_BLK_IDX], addrRegs[DST_PAGE_IDX]);
    ersNxt    = ERS_W'(srcBlk) << ERS_SHIFT;
  end

  // Registered derived outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSector  <= '0;
      dstSector  <= '0;
      eraseBase  <= '0;
      bufIsData  <= 1'b0;
      bufDataSel <= 1'b0;
      bufSecOfs  <= '0;
      secCount   <= CNT_W'(CNT_MAX);
    end else begin
      srcSector  <= srcSecNxt;
      dstSector  <= dstSecNxt;
      eraseBase  <= ersNxt;
      bufIsData  <= bufAddr[3];
      bufDataSel <= bufAddr[2];
      bufSecOfs  <= bufAddr[1:0];
      secCount   <= cntVal;
    end
  end

  assign eraseCount = 16'(1 << ERS_SHIFT);

  // Read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.rdAddr) begin
      rdData <= addrRegs[strb.areg];
    end else if (strb.rdBuf) begin
      rdData <= bufRead;
    end else if (strb.rdNone) begin
      rdData <= '0;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secCount >= CNT_W'(1)) && (secCount <= CNT_W'(CNT_MAX)));

  // R7
  buf_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bufWr |-> ##2 (bufIsData == $past(wrData[11], 2)
                        && bufSecOfs == $past(wrData[9:8], 2)));

  // R11
  sec_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.addrWr) && !$past(strb.addrWr, 2)) |-> $stable(srcSector));

  // R10
  rd_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdNone |=> (rdData == 16'h0000));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdAddr || strb.rdBuf || strb.rdNone) |=> $stable(rdData));

endmodule

// File: rtl/flash_sector_decoder.sv
module flash_sector_decoder
  import sec_dec_pkg::*;
#(
  parameter int         PAGE_SHIFT = 11,
  parameter logic [7:0] DEV_ID     = 8'h48,
  parameter int         BLK_W      = 14,
  parameter int         SEC_W      = BLK_W + 6 + (PAGE_SHIFT - 9) + 1,
  parameter int         ERS_W      = BLK_W + 6 + (PAGE_SHIFT - 9),
  parameter int         CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       regIdx,
  input  logic             wrEn,
  input  logic [15:0]      wrData,
  input  logic             rdEn,
  output logic [15:0]      rdData,
  output logic [SEC_W-1:0] srcSector,
  output logic [SEC_W-1:0] dstSector,
  output logic [ERS_W-1:0] eraseBase,
  output logic [15:0]      eraseCount,
  output logic             bufIsData,
  output logic             bufDataSel,
  output logic [1:0]       bufSecOfs,
  output logic [CNT_W-1:0] secCount
);

  regStrobe_t strb;

  sec_dec_ctrl ctrl_i (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .regIdx (regIdx),
    .strb   (strb)
  );

  sec_dec_path #(
    .PAGE_SHIFT (PAGE_SHIFT),
    .DEV_ID     (DEV_ID),
    .BLK_W      (BLK_W),
    .SEC_W      (SEC_W),
    .ERS_W      (ERS_W),
    .CNT_W      (CNT_W)
  ) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .rdData     (rdData),
    .srcSector  (srcSector),
    .dstSector  (dstSector),
    .eraseBase  (eraseBase),
    .eraseCount (eraseCount),
    .bufIsData  (bufIsData),
    .bufDataSel (bufDataSel),
    .bufSecOfs  (bufSecOfs),
    .secCount   (secCount)
  );

endmodule

// File: tb/flash_sector_decoder_tb.sv
module flash_sector_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regIdx = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;
  logic [22:0] srcSector, dstSector;
  logic [21:0] eraseBase;
  logic [15:0] eraseCount;
  logic        bufIsData, bufDataSel;
  logic [1:0]  bufSecOfs;
  logic [2:0]  secCount;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #2.5 clk = ~clk;

  flash_sector_decoder dut_i (
    .clk(clk), .rstN(rstN), .regIdx(regIdx), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .srcSector(srcSector),
    .dstSector(dstSector), .eraseBase(eraseBase), .eraseCount(eraseCount),
    .bufIsData(bufIsData), .bufDataSel(bufDataSel), .bufSecOfs(bufSecOfs),
    .secCount(secCount)
  );

  typedef struct packed {
    logic [15:0] blk;
    logic [15:0] pg;
    logic [31:0] sec;
    logic [31:0] ers;
  } vec_t;

  // Hand-computed from R3/R4/R6 with 2 KB pages, density mask 0x400
  localparam vec_t VECS [7] = '{
    '{16'h0000, 16'h0000, 32'd0,      32'd0},
    '{16'h0001, 16'h0000, 32'd256,    32'd256},
    '{16'h0000, 16'h0007, 32'd7,      32'd0},
    '{16'h0ABC, 16'h00FF, 32'd703743, 32'd703488},
    '{16'h8003, 16'h0010, 32'd262928, 32'd262912},
    '{16'hF123, 16'hFF01, 32'd336641, 32'd336640},
    '{16'h7005, 16'h0000, 32'd1280,   32'd1280}
  };

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] idx, input logic [15:0] val);
    @(negedge clk);
    regIdx = idx; wrData = val; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] idx, output logic [15:0] val);
    @(negedge clk);
    regIdx = idx; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    val = rdData;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();

    // R1 reset state
    chk("R1 srcSector", 32'(srcSector), 0);
    chk("R1 secCount", 32'(secCount), 4);
    chk("R1 bufIsData", 32'(bufIsData), 0);
    regRead(4'd8, rv);  chk("R1 buf readback", 32'(rv), 32'h0002);
    regRead(4'd5, rv);  chk("R1 addr reg", 32'(rv), 0);
    chk("R6 eraseCount", 32'(eraseCount), 256);

    // R3 R4 R6 vector walk
    foreach (VECS[i]) begin
      regWrite(4'd0, VECS[i].blk);
      regWrite(4'd7, VECS[i].pg);
      settle();
      chk("R3 srcSector", 32'(srcSector), VECS[i].sec);
      chk("R6 eraseBase", 32'(eraseBase), VECS[i].ers);
    end

    // R11 latency: first edge after write shows old value
    regWrite(4'd7, 16'h0000);
    chk("R11 old value", 32'(srcSector), 32'd1280);
    settle();
    chk("R11 new value", 32'(srcSector), 32'd1280);
    regWrite(4'd0, 16'h0002);
    chk("R11 before update", 32'(srcSector), 32'd1280);
    settle();
    chk("R11 after update", 32'(srcSector), 32'd512);

    // R5 destination pair
    regWrite(4'd2, 16'h0002);
    regWrite(4'd3, 16'h0005);
    settle();
    chk("R5 dstSector", 32'(dstSector), 32'd517);
    chk("R5 src untouched", 32'(srcSector), 32'd512);

    // R2 readback
    regWrite(4'd4, 16'hA5C3);
    regWrite(4'd6, 16'hFFFF);
    regRead(4'd4, rv);  chk("R2 idx4", 32'(rv), 32'hA5C3);
    regRead(4'd6, rv);  chk("R2 idx6", 32'(rv), 32'hFFFF);
    regRead(4'd3, rv);  chk("R2 idx3", 32'(rv), 32'h0005);

    // R7 R8 R9 buffer register
    regWrite(4'd8, 16'h0E03);
    settle();
    chk("R7 bufIsData", 32'(bufIsData), 1);
    chk("R7 bufDataSel", 32'(bufDataSel), 1);
    chk("R7 bufSecOfs", 32'(bufSecOfs), 2);
    chk("R8 count 3", 32'(secCount), 3);
    regRead(4'd8, rv);  chk("R9 readback 0E03", 32'(rv), 32'h0E02);

    regWrite(4'd8, 16'h0500);
    settle();
    chk("R7 boot sel", 32'(bufIsData), 0);
    chk("R7 offset 1", 32'(bufSecOfs), 1);
    chk("R8 zero means 4", 32'(secCount), 4);
    regRead(4'd8, rv);  chk("R9 readback 0500", 32'(rv), 32'h0502);

    regWrite(4'd8, 16'h0801);
    settle();
    chk("R8 count 1", 32'(secCount), 1);
    regRead(4'd8, rv);  chk("R9 readback 0801", 32'(rv), 32'h0800);

    regWrite(4'd8, 16'hF902);
    settle();
    chk("R7 upper ignored sel", 32'(bufDataSel), 0);
    chk("R7 upper ignored data", 32'(bufIsData), 1);
    chk("R8 count 2", 32'(secCount), 2);
    regRead(4'd8, rv);  chk("R9 readback F902", 32'(rv), 32'h0900);

    // R10 unmapped indices
    regWrite(4'd12, 16'hFFFF);
    regWrite(4'd9, 16'h0000);
    settle();
    chk("R10 src unchanged", 32'(srcSector), 32'd512);
    chk("R10 count unchanged", 32'(secCount), 2);
    regRead(4'd12, rv); chk("R10 read idx12", 32'(rv), 0);
    regRead(4'd8, rv);  chk("R10 buf unchanged", 32'(rv), 32'h0900);
    regRead(4'd0, rv);  chk("R10 blk unchanged", 32'(rv), 32'h0002);

    // R12 hold while rdEn low
    regRead(4'd4, rv);
    settle();
    settle();
    chk("R12 hold", 32'(rdData), 32'hA5C3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule